// File: doc/BRIEF.md
# Configurable Bidirectional I/O Cell

This block models one programmable I/O slice sitting between a group of pads and the internal fabric. A set of static configuration inputs chooses whether the slice listens to the pad, drives it, or does both under a tristate control. It also chooses how the input value is captured: a level-sensitive latch or an edge-triggered flip-flop, clocked from a fast dedicated edge clock or the general system clock, in either polarity. Further inputs choose how a local set/reset and a clock enable interact, whether that set/reset is synchronous or asynchronous, whether a global set/reset reaches the slice, and how two fabric output signals are turned into the pad value.

The slice is a sampled model. A single model clock `clk` runs much faster than the cell clocks. The system clock and the edge clock arrive as ordinary inputs, and the slice detects their levels and rising transitions tick by tick. Every storage element updates on `clk`. Asynchronous behaviour means the effect is visible at the ports in the same tick, without waiting for a cell clock edge. The pad is three plain signals: the value from the pad, the value to it, and the enable. When the enable is low the slice drives zero, and the outside world resolves the pad to high impedance. Configuration is expected to change only while `rst_n` is low. All `DW` pads of the slice share one configuration.

Top module: `pio_slice`

## Requirements
- R1: The pad enable follows the direction code: 0 or 3 (input) gives all zeros, 1 (output) gives all ones, 2 (bidirectional) gives `ts_en` on every bit. Whenever the enable is low, `pad_o` is zero.
- R2: `in_raw` equals `pad_i` in input and bidirectional modes, including while the slice drives the pad, and is zero in output mode. The capture element sees the same gated value.
- R3: With `cfg_latch`=0 the capture element changes only on a tick where the selected clock level has gone from 0 to 1 since the previous tick and `ce` is 1. The new value appears on `in_cap` one tick later.
- R4: With `cfg_latch`=1 the capture element is transparent in the same tick whenever the selected clock level is 1 and `ce` is 1. Otherwise it holds its value.
- R5: `cfg_clk_edge`=1 selects `ck_edge` and 0 selects `ck_sys`. `cfg_clk_inv`=1 inverts the selected clock before level and edge detection.
- R6: In synchronous mode (`cfg_async`=0), `cfg_lsr_first`=1 lets `lsr` load the set/reset value whenever the element would update, whatever `ce` is. `cfg_lsr_first`=0 lets `lsr` act only when `ce` is 1.
- R7: In asynchronous mode (`cfg_async`=1), `lsr`=1 forces `in_cap` to the set/reset value in the same tick, whatever the clock, `ce` or the priority setting.
- R8: The set/reset value is all ones when `cfg_set`=1 and all zeros when `cfg_set`=0.
- R9: `gsr`=1 with `cfg_gsr_en`=1 loads the set/reset value into the capture element and zero into the output register on the next tick, whatever the clock. With `cfg_gsr_en`=0 `gsr` has no effect. `rst_n`=0 clears both elements to zero on the next tick.
- R10: Output select 0 drives the output register loaded from `out1`, and select 1 drives it loaded from `out2`. The register loads on a rising clock tick with `ce`=1, and the new value appears one tick later.
- R11: Output select 2 or 3 drives, in the same tick, a bitwise function of `out1` and `out2` chosen by `cfg_op`: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR, and 6 or 7 AND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dir | input | 2 | Direction code: 0 input, 1 output, 2 bidirectional, 3 input |
| cfg_latch | input | 1 | 1 selects the latch capture element, 0 the flip-flop |
| cfg_clk_edge | input | 1 | 1 selects the edge clock, 0 the system clock |
| cfg_clk_inv | input | 1 | Inverts the selected clock |
| cfg_async | input | 1 | 1 makes the local set/reset asynchronous |
| cfg_lsr_first | input | 1 | 1 gives set/reset priority over clock enable |
| cfg_set | input | 1 | Set/reset value: 1 sets, 0 clears |
| cfg_gsr_en | input | 1 | Lets the global set/reset reach the slice |
| cfg_omux | input | 2 | Output source: 0 reg(out1), 1 reg(out2), 2/3 logic gate |
| cfg_op | input | 3 | Gate function code |
| ck_sys | input | 1 | System cell clock (sampled) |
| ck_edge | input | 1 | Fast edge cell clock (sampled) |
| ce | input | 1 | Clock enable |
| lsr | input | 1 | Local set/reset |
| gsr | input | 1 | Global set/reset |
| ts_en | input | 1 | Tristate control, 1 drives in bidirectional mode |
| out1 | input | DW | First fabric output data |
| out2 | input | DW | Second fabric output data |
| in_raw | output | DW | Direct pad value to the fabric |
| in_cap | output | DW | Captured pad value to the fabric |
| pad_i | input | DW | Value arriving from the pads |
| pad_o | output | DW | Value driven to the pads |
| pad_oe | output | DW | Pad output enable |

## Verification
A corrupted capture state shows on `in_cap` at once in flip-flop mode, because the port reads the stored value directly. In latch mode it shows whenever the selected clock is low or `ce` is low. A stale edge-detection level shows up as a missed or extra capture on the first clock transition after it. That transition also moves the output register, so the fault appears on `pad_o` within one tick whenever a registered output source is selected. A wrong output register value is on `pad_o` in the same tick for select 0 or 1 whenever the pad is enabled, and each tick is compared against a behavioural model.

// File: rtl/pio_pkg.sv
// Shared encodings for the configurable I/O slice.
// Assumes every configuration code is held static outside reset.
package pio_pkg;

    typedef enum logic [1:0] {
        DIR_IN    = 2'd0,
        DIR_OUT   = 2'd1,
        DIR_BIDIR = 2'd2,
        DIR_IN2   = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        OM_REG1  = 2'd0,
        OM_REG2  = 2'd1,
        OM_GATE  = 2'd2,
        OM_GATE2 = 2'd3
    } omux_e;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_NAND = 3'd1,
        OP_OR   = 3'd2,
        OP_NOR  = 3'd3,
        OP_XOR  = 3'd4,
        OP_XNOR = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } gate_e;

    // One bit of the selectable two-input output gate
    function automatic logic gate_bit(gate_e op, logic a, logic b);
        case (op)
            OP_NAND: return ~(a & b);
            OP_OR:   return a | b;
            OP_NOR:  return ~(a | b);
            OP_XOR:  return a ^ b;
            OP_XNOR: return ~(a ^ b);
            default: return a & b;
        endcase
    endfunction

endpackage

// File: rtl/pio_clk_sel.sv
// Picks the capture clock, applies polarity and detects its rising edge.
// Assumes ck_sys and ck_edge change far slower than clk; each is sampled
// once per tick. The previous level resets to 1 so that reset release
// never produces a false edge.
module pio_clk_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_sys,
    input  logic ck_edge,
    input  logic sel_edge,
    input  logic invert,
    output logic lvl,
    output logic rise
);

    logic lvl_q;

    // Selected clock level after optional inversion
    always_comb begin
        lvl  = (sel_edge ? ck_edge : ck_sys) ^ invert;
        rise = lvl & ~lvl_q;
    end

    // Remember last tick's level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

endmodule

// File: rtl/pio_capture.sv
// Input capture element: latch or flip-flop with clock enable, local
// set/reset (sync with selectable priority, or async) and global set/reset.
// Assumes configuration inputs are static outside reset.
module pio_capture #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl,
    input  logic          rise,
    input  logic          latch_mode,
    input  logic          async_mode,
    input  logic          lsr_first,
    input  logic          set_val,
    input  logic          gsr_hit,
    input  logic          ce,
    input  logic          lsr,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    localparam logic [DW-1:0] ZERO = '0;

    logic [DW-1:0] q_r;
    logic [DW-1:0] nxt;
    logic [DW-1:0] sv;
    logic          force_now;

    // Value the element would take when allowed to update
    always_comb begin
        sv        = {DW{set_val}};
        force_now = async_mode & lsr;
        if (async_mode)     nxt = ce ? d : q_r;
        else if (lsr_first) nxt = lsr ? sv : (ce ? d : q_r);
        else                nxt = ce ? (lsr ? sv : d) : q_r;
    end

    // Visible value: async override, then latch transparency, then store
    always_comb begin
        if (force_now)              q = sv;
        else if (latch_mode && lvl) q = nxt;
        else                        q = q_r;
    end

    // Stored state update per model tick
    always_ff @(posedge clk) begin
        if (!rst_n)         q_r <= ZERO;
        else if (gsr_hit)   q_r <= sv;
        else if (force_now) q_r <= sv;
        else if (latch_mode) q_r <= q;
        else if (rise)      q_r <= nxt;
    end

endmodule

// File: rtl/pio_out_path.sv
// Output path: output register fed by one of two fabric signals, a
// selectable two-input gate, source select and pad direction control.
// Assumes configuration inputs are static outside reset.
module pio_out_path #(
    parameter int DW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rise,
    input  logic           ce,
    input  logic           gsr_hit,
    input  pio_pkg::omux_e omux,
    input  pio_pkg::gate_e op,
    input  pio_pkg::dir_e  dir,
    input  logic           ts_en,
    input  logic [DW-1:0]  out1,
    input  logic [DW-1:0]  out2,
    output logic [DW-1:0]  val_o,
    output logic [DW-1:0]  pad_o,
    output logic [DW-1:0]  pad_oe
);
    import pio_pkg::*;

    logic [DW-1:0] oreg;
    logic [DW-1:0] gate_v;
    logic          drive;

    // One gate per pad bit
    for (genvar g = 0; g < DW; g++) begin : g_gate
        assign gate_v[g] = gate_bit(op, out1[g], out2[g]);
    end

    // Output register loads on an enabled rising cell-clock tick
    always_ff @(posedge clk) begin
        if (!rst_n)          oreg <= '0;
        else if (gsr_hit)    oreg <= '0;
        else if (rise && ce) oreg <= (omux == OM_REG2) ? out2 : out1;
    end

    // Source select and pad direction
    always_comb begin
        val_o  = (omux == OM_REG1 || omux == OM_REG2) ? oreg : gate_v;
        drive  = (dir == DIR_OUT) || (dir == DIR_BIDIR && ts_en);
        pad_oe = {DW{drive}};
        pad_o  = drive ? val_o : '0;
    end

endmodule

// File: rtl/pio_slice.sv
// Top of the configurable bidirectional I/O slice. Wires the clock
// selector, the input capture element and the output path together.
// Assumes configuration is static while rst_n is high.
module pio_slice #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_dir,
    input  logic          cfg_latch,
    input  logic          cfg_clk_edge,
    input  logic          cfg_clk_inv,
    input  logic          cfg_async,
    input  logic          cfg_lsr_first,
    input  logic          cfg_set,
    input  logic          cfg_gsr_en,
    input  logic [1:0]    cfg_omux,
    input  logic [2:0]    cfg_op,
    input  logic          ck_sys,
    input  logic          ck_edge,
    input  logic          ce,
    input  logic          lsr,
    input  logic          gsr,
    input  logic          ts_en,
    input  logic [DW-1:0] out1,
    input  logic [DW-1:0] out2,
    output logic [DW-1:0] in_raw,
    output logic [DW-1:0] in_cap,
    input  logic [DW-1:0] pad_i,
    output logic [DW-1:0] pad_o,
    output logic [DW-1:0] pad_oe
);
    import pio_pkg::*;

    logic          act_lvl;
    logic          act_rise;
    logic          gsr_hit;
    logic [DW-1:0] out_val;
    dir_e          dir_c;

    // Global set/reset gating and input path gating
    always_comb begin
        dir_c   = dir_e'(cfg_dir);
        gsr_hit = gsr & cfg_gsr_en;
        in_raw  = (dir_c == DIR_OUT) ? '0 : pad_i;
    end

    pio_clk_sel u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .ck_sys   (ck_sys),
        .ck_edge  (ck_edge),
        .sel_edge (cfg_clk_edge),
        .invert   (cfg_clk_inv),
        .lvl      (act_lvl),
        .rise     (act_rise)
    );

    pio_capture #(.DW(DW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (act_lvl),
        .rise       (act_rise),
        .latch_mode (cfg_latch),
        .async_mode (cfg_async),
        .lsr_first  (cfg_lsr_first),
        .set_val    (cfg_set),
        .gsr_hit    (gsr_hit),
        .ce         (ce),
        .lsr        (lsr),
        .d          (in_raw),
        .q          (in_cap)
    );

    pio_out_path #(.DW(DW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (act_rise),
        .ce      (ce),
        .gsr_hit (gsr_hit),
        .omux    (omux_e'(cfg_omux)),
        .op      (gate_e'(cfg_op)),
        .dir     (dir_c),
        .ts_en   (ts_en),
        .out1    (out1),
        .out2    (out2),
        .val_o   (out_val),
        .pad_o   (pad_o),
        .pad_oe  (pad_oe)
    );

endmodule

// File: rtl/pio_slice_chk.sv
// Property checker for pio_slice, attached by bind. Assumes configuration
// is static while rst_n is high.
module pio_slice_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_dir,
    input logic          cfg_latch,
    input logic          cfg_async,
    input logic          cfg_set,
    input logic          cfg_gsr_en,
    input logic [1:0]    cfg_omux,
    input logic          lsr,
    input logic          gsr,
    input logic          rise,
    input logic [DW-1:0] in_raw,
    input logic [DW-1:0] in_cap,
    input logic [DW-1:0] out_val,
    input logic [DW-1:0] pad_o,
    input logic [DW-1:0] pad_oe
);

    a_r1_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir == 2'd0 || cfg_dir == 2'd3) |-> pad_oe == '0);

    a_r1_output_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir == 2'd1) |-> pad_oe == '1);

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe == '0) |-> pad_o == '0);

    a_r2_no_raw_in_output: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir == 2'd1) |-> in_raw == '0);

    a_r7_async_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_async && lsr) |-> in_cap == {DW{cfg_set}});

    a_r3_ff_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_latch && !cfg_async && !rise && !(gsr && cfg_gsr_en)) |=> $stable(in_cap));

    a_r9_gsr_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (gsr && cfg_gsr_en && !cfg_latch) |=> in_cap == {DW{cfg_set}});

    a_r10_oreg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_omux[1] && !rise && !(gsr && cfg_gsr_en)) |=> $stable(out_val));

endmodule

bind pio_slice pio_slice_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_dir    (cfg_dir),
    .cfg_latch  (cfg_latch),
    .cfg_async  (cfg_async),
    .cfg_set    (cfg_set),
    .cfg_gsr_en (cfg_gsr_en),
    .cfg_omux   (cfg_omux),
    .lsr        (lsr),
    .gsr        (gsr),
    .rise       (act_rise),
    .in_raw     (in_raw),
    .in_cap     (in_cap),
    .out_val    (out_val),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe)
);

// File: tb/test_pio_slice.sv
// Self-checking bench: behavioural reference updated each clock, compared
// with the outputs at every falling edge before new stimulus is applied.
module test_pio_slice;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 4;
    localparam int TICKS_PER_CFG = 60;

    logic          clk;
    logic          rst_n;
    logic [1:0]    cfg_dir;
    logic          cfg_latch, cfg_clk_edge, cfg_clk_inv, cfg_async;
    logic          cfg_lsr_first, cfg_set, cfg_gsr_en;
    logic [1:0]    cfg_omux;
    logic [2:0]    cfg_op;
    logic          ck_sys, ck_edge, ce, lsr, gsr, ts_en;
    logic [DW-1:0] out1, out2, pad_i;
    logic [DW-1:0] in_raw, in_cap, pad_o, pad_oe;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference state
    logic          m_prev;
    logic [DW-1:0] m_cap;
    logic [DW-1:0] m_oreg;

    pio_slice #(.DW(DW)) i_pio_slice (
        .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_latch(cfg_latch),
        .cfg_clk_edge(cfg_clk_edge), .cfg_clk_inv(cfg_clk_inv),
        .cfg_async(cfg_async), .cfg_lsr_first(cfg_lsr_first),
        .cfg_set(cfg_set), .cfg_gsr_en(cfg_gsr_en), .cfg_omux(cfg_omux),
        .cfg_op(cfg_op), .ck_sys(ck_sys), .ck_edge(ck_edge), .ce(ce),
        .lsr(lsr), .gsr(gsr), .ts_en(ts_en), .out1(out1), .out2(out2),
        .in_raw(in_raw), .in_cap(in_cap), .pad_i(pad_i), .pad_o(pad_o),
        .pad_oe(pad_oe)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---- behavioural expectations from the requirements ----
    function automatic logic m_level();
        return (cfg_clk_edge ? ck_edge : ck_sys) ^ cfg_clk_inv;   // R5
    endfunction

    function automatic logic [DW-1:0] m_setv();
        return cfg_set ? {DW{1'b1}} : {DW{1'b0}};                 // R8
    endfunction

    function automatic logic [DW-1:0] m_raw();
        return (cfg_dir == 2'd1) ? {DW{1'b0}} : pad_i;            // R2
    endfunction

    function automatic logic [DW-1:0] m_update();                 // R6
        if (cfg_async)          return ce ? m_raw() : m_cap;
        if (cfg_lsr_first && lsr) return m_setv();
        if (!ce)                return m_cap;
        return lsr ? m_setv() : m_raw();
    endfunction

    function automatic logic [DW-1:0] m_cap_vis();
        if (cfg_async && lsr)       return m_setv();              // R7
        if (cfg_latch && m_level()) return m_update();            // R4
        return m_cap;                                             // R3
    endfunction

    function automatic logic m_drive();                           // R1
        return (cfg_dir == 2'd1) || (cfg_dir == 2'd2 && ts_en);
    endfunction

    function automatic logic [DW-1:0] m_gate();                   // R11
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) begin
            case (cfg_op)
                3'd1: r[i] = !(out1[i] && out2[i]);
                3'd2: r[i] = out1[i] || out2[i];
                3'd3: r[i] = !(out1[i] || out2[i]);
                3'd4: r[i] = out1[i] != out2[i];
                3'd5: r[i] = out1[i] == out2[i];
                default: r[i] = out1[i] && out2[i];
            endcase
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] m_pad_o();                  // R10
        if (!m_drive()) return '0;
        return cfg_omux[1] ? m_gate() : m_oreg;
    endfunction

    // Reference state advance on each model tick
    always @(posedge clk) begin
        logic rising;
        logic [DW-1:0] vis;
        rising = m_level() && !m_prev;
        vis    = m_cap_vis();
        if (!rst_n) begin
            m_cap  = '0; m_oreg = '0; m_prev = 1'b1;              // R9
        end else begin
            if (gsr && cfg_gsr_en)      m_cap = m_setv();         // R9
            else if (cfg_async && lsr)  m_cap = m_setv();
            else if (cfg_latch)         m_cap = vis;
            else if (rising)            m_cap = m_update();
            if (gsr && cfg_gsr_en)      m_oreg = '0;
            else if (rising && ce)      m_oreg = (cfg_omux == 2'd1) ? out2 : out1;
            m_prev = m_level();
        end
    end

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Compare every output against the reference
    task automatic compare_all();
        string ctag;
        ctag = cfg_latch ? "R4" : "R3";
        if (cfg_async && lsr)        ctag = {ctag, " R7"};
        else if (lsr)                ctag = {ctag, " R6 R8"};
        if (gsr && cfg_gsr_en)       ctag = {ctag, " R9"};
        if (cfg_clk_edge || cfg_clk_inv) ctag = {ctag, " R5"};
        check("R1 pad_oe", pad_oe, {DW{m_drive()}});
        check("R2 in_raw", in_raw, m_raw());
        check({ctag, " in_cap"}, in_cap, m_cap_vis());
        check(cfg_omux[1] ? "R11 pad_o" : "R10 pad_o", pad_o, m_pad_o());
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet_inputs();
        ck_sys = 0; ck_edge = 0; ce = 0; lsr = 0; gsr = 0; ts_en = 0;
        out1 = '0; out2 = '0; pad_i = '0;
    endtask

    task automatic random_inputs();
        if ($urandom % 3 == 0) ck_sys  = ~ck_sys;
        if ($urandom % 2 == 0) ck_edge = ~ck_edge;
        ce    = ($urandom % 4) != 0;
        lsr   = ($urandom % 8) == 0;
        gsr   = ($urandom % 32) == 0;
        ts_en = $urandom % 2;
        out1  = DW'($urandom);
        out2  = DW'($urandom);
        pad_i = DW'($urandom);
    endtask

    // Configure under reset, then check the reset state
    task automatic configure(int k);
        rst_n = 0;
        quiet_inputs();
        cfg_latch     = k[0];
        cfg_clk_edge  = k[1];
        cfg_clk_inv   = k[2];
        cfg_async     = k[3];
        cfg_lsr_first = k[4];
        cfg_set       = k[5];
        cfg_gsr_en    = k[6];
        cfg_dir       = 2'($urandom % 4);
        cfg_omux      = 2'($urandom % 4);
        cfg_op        = 3'($urandom % 8);
        tick();
        tick();
        check("R9 reset clears in_cap", in_cap, '0);
        rst_n = 1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        rst_n = 0;
        quiet_inputs();
        cfg_dir = 0; cfg_latch = 0; cfg_clk_edge = 0; cfg_clk_inv = 0;
        cfg_async = 0; cfg_lsr_first = 0; cfg_set = 0; cfg_gsr_en = 0;
        cfg_omux = 0; cfg_op = 0;
        for (int k = 0; k < 128; k++) begin
            configure(k);
            tick();
            // R7: asynchronous set/reset visible in the same tick
            if (cfg_async) begin
                lsr = 1;
                #1;
                check("R7 async override same tick", in_cap, m_setv());
                tick();
                lsr = 0;
            end
            // R11: directed gate pattern, out1=1100 out2=1010
            if (cfg_omux[1]) begin
                out1 = 4'b1100; out2 = 4'b1010;
                #1;
                check("R11 gate pattern", i_pio_slice.u_out.val_o, m_gate());
                tick();
            end
            for (int t = 0; t < TICKS_PER_CFG; t++) begin
                random_inputs();
                tick();
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule